// File: doc/BRIEF.md
# Condition Evaluator with Loop Branch Control

This block tests a 4-bit condition selector against the negative, zero, overflow and carry flags. It reports the outcome in one of three forms, picked by a 2-bit mode input. In branch mode it gives a branch-taken decision. In set mode it gives a byte that is either all ones or all zeros. In loop mode it gives a counted-loop step: an exit decision, an updated counter and a branch-taken decision.

In loop mode the sense of the condition is the reverse of branch mode. A true condition ends the loop at once and leaves the counter as it was. A false condition decrements the low 16 bits of the counter. The branch is then taken unless the decremented value is all ones.

Only the low half of the counter register is touched. The upper bits pass through unchanged in every mode. All outputs are registered, so a result appears one clock after its inputs are presented.

Top module: `cond_branch_unit`

## Requirements
- R1: Condition codes are T=0 (always true), F=1 (always false), CC=4 (C=0), CS=5 (C=1), NE=6 (Z=0), EQ=7 (Z=1), VC=8 (V=0), VS=9 (V=1), PL=10 (N=0) and MI=11 (N=1).
- R2: Code 2 (HI) holds when C=0 and Z=0. Code 3 (LS) holds when C=1 or Z=1.
- R3: Code 12 (GE) holds when N equals V. Code 13 (LT) holds when N differs from V. Code 14 (GT) holds when Z=0 and N equals V. Code 15 (LE) holds when Z=1 or N differs from V.
- R4: In branch mode (mode 0), `taken_o` equals the condition, except that code 1 is always taken. In this mode `exit_o` and `set_byte_o` are 0 and `cnt_o` equals `cnt_i`.
- R5: In set mode (mode 1), `set_byte_o` is 0xFF when the condition holds and 0x00 when it does not. `taken_o` and `exit_o` are 0 and `cnt_o` equals `cnt_i`.
- R6: In loop mode (mode 2) with the condition true, `exit_o` is 1, `taken_o` is 0 and `cnt_o` equals `cnt_i`, with no decrement.
- R7: In loop mode with the condition false, the low 16 bits of `cnt_o` are the low 16 bits of `cnt_i` minus one, modulo 2^16. `exit_o` is 0, and `taken_o` is 1 unless the new low half is 0xFFFF.
- R8: Bits 31..16 of `cnt_o` always equal bits 31..16 of `cnt_i`.
- R9: Feeding `cnt_o` back as `cnt_i` in loop mode with code 1 and a start value of 7 gives 8 passes. The first 7 passes are taken, the eighth is not, and the low half ends at 0xFFFF.
- R10: Mode 3 is idle: `taken_o`, `exit_o` and `set_byte_o` are 0, and `cnt_o` equals `cnt_i`.
- R11: Outputs appear one clock after the inputs. While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 0 branch, 1 set, 2 loop, 3 idle |
| code_i | input | 4 | Condition selector |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_v_i | input | 1 | Overflow flag |
| flag_c_i | input | 1 | Carry flag |
| cnt_i | input | 32 | Counter register value |
| taken_o | output | 1 | Branch taken |
| exit_o | output | 1 | Loop falls through on a true condition |
| set_byte_o | output | 8 | All-ones or all-zeros condition byte |
| cnt_o | output | 32 | Counter with updated low half |

## Verification
In loop mode, two events can fall in the same cycle: the condition can become true just as the counter's low half is zero and about to expire. The sweep provokes this by applying every code and flag combination with low halves of 0 and 1. The expected result is that the exit wins with the counter untouched. When the condition is false, a low half of 0 must wrap to 0xFFFF without a branch, and a low half of 1 must reach 0 and branch. A feedback run started at 7 judges the whole counted loop by its pass count and its final counter value.

// File: rtl/cbu_pkg.sv
`timescale 1ns/1ps
package cbu_pkg;
    typedef enum logic [1:0] {
        MODE_BRANCH = 2'd0,
        MODE_SET    = 2'd1,
        MODE_LOOP   = 2'd2,
        MODE_IDLE   = 2'd3
    } mode_e;

    typedef enum logic [3:0] {
        CND_T  = 4'd0,  CND_F  = 4'd1,
        CND_HI = 4'd2,  CND_LS = 4'd3,
        CND_CC = 4'd4,  CND_CS = 4'd5,
        CND_NE = 4'd6,  CND_EQ = 4'd7,
        CND_VC = 4'd8,  CND_VS = 4'd9,
        CND_PL = 4'd10, CND_MI = 4'd11,
        CND_GE = 4'd12, CND_LT = 4'd13,
        CND_GT = 4'd14, CND_LE = 4'd15
    } cond_e;
endpackage

// File: rtl/cbu_cond_eval.sv
`timescale 1ns/1ps
// Codes come in pairs; the odd member is the inverse of the even one (R1, R2, R3).
module cbu_cond_eval (
    input  logic [3:0] code_i,
    input  logic       n_i,
    input  logic       z_i,
    input  logic       v_i,
    input  logic       c_i,
    output logic       hold_o
);
    logic base;

    always_comb begin
        unique case (code_i[3:1])
            3'd0: base = 1'b1;
            3'd1: base = !c_i && !z_i;
            3'd2: base = !c_i;
            3'd3: base = !z_i;
            3'd4: base = !v_i;
            3'd5: base = !n_i;
            3'd6: base = (n_i == v_i);
            default: base = !z_i && (n_i == v_i);
        endcase
        hold_o = base ^ code_i[0];
    end
endmodule

// File: rtl/cbu_loop_step.sv
`timescale 1ns/1ps
module cbu_loop_step #(
    parameter int LOOP_W = 16
) (
    input  logic              hold_i,
    input  logic [LOOP_W-1:0] cnt_lo_i,
    output logic              exit_o,
    output logic              taken_o,
    output logic [LOOP_W-1:0] cnt_lo_o
);
    logic [LOOP_W-1:0] dec;

    always_comb begin
        dec      = cnt_lo_i - LOOP_W'(1);
        exit_o   = hold_i;
        cnt_lo_o = hold_i ? cnt_lo_i : dec;
        taken_o  = !hold_i && (dec != {LOOP_W{1'b1}});
    end
endmodule

// File: rtl/cond_branch_unit.sv
`timescale 1ns/1ps
module cond_branch_unit #(
    parameter int CNT_W  = 32,
    parameter int LOOP_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [3:0]        code_i,
    input  logic              flag_n_i,
    input  logic              flag_z_i,
    input  logic              flag_v_i,
    input  logic              flag_c_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              taken_o,
    output logic              exit_o,
    output logic [BYTE_W-1:0] set_byte_o,
    output logic [CNT_W-1:0]  cnt_o
);
    import cbu_pkg::*;

    localparam int UPPER_W = CNT_W - LOOP_W;

    typedef struct packed {
        logic              taken;
        logic              exit;
        logic [BYTE_W-1:0] set_byte;
        logic [CNT_W-1:0]  cnt;
    } out_t;

    out_t              out_d, out_q;
    logic              hold;
    logic              lp_exit, lp_taken;
    logic [LOOP_W-1:0] lp_cnt;

    cbu_cond_eval u_eval (
        .code_i (code_i),
        .n_i    (flag_n_i),
        .z_i    (flag_z_i),
        .v_i    (flag_v_i),
        .c_i    (flag_c_i),
        .hold_o (hold)
    );

    cbu_loop_step #(.LOOP_W(LOOP_W)) u_step (
        .hold_i   (hold),
        .cnt_lo_i (cnt_i[LOOP_W-1:0]),
        .exit_o   (lp_exit),
        .taken_o  (lp_taken),
        .cnt_lo_o (lp_cnt)
    );

    always_comb begin
        out_d     = '0;
        out_d.cnt = cnt_i;
        unique case (mode_e'(mode_i))
            MODE_BRANCH: out_d.taken = hold || (code_i == CND_F);
            MODE_SET:    out_d.set_byte = {BYTE_W{hold}};
            MODE_LOOP: begin
                out_d.exit  = lp_exit;
                out_d.taken = lp_taken;
                out_d.cnt   = {cnt_i[CNT_W-1 -: UPPER_W], lp_cnt};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign taken_o    = out_q.taken;
    assign exit_o     = out_q.exit;
    assign set_byte_o = out_q.set_byte;
    assign cnt_o      = out_q.cnt;
endmodule

// File: rtl/cbu_checker.sv
`timescale 1ns/1ps
module cbu_checker #(
    parameter int CNT_W  = 32,
    parameter int LOOP_W = 16,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_i,
    input logic [3:0]        code_i,
    input logic [CNT_W-1:0]  cnt_i,
    input logic              taken_o,
    input logic              exit_o,
    input logic [BYTE_W-1:0] set_byte_o,
    input logic [CNT_W-1:0]  cnt_o
);
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_byte_form_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_byte_o == '0) || (set_byte_o == '1));

    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exit_o, taken_o}));

    p_exit_keep_r6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        exit_o |-> (cnt_o == $past(cnt_i)));

    p_upper_r8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        cnt_o[CNT_W-1:LOOP_W] == $past(cnt_i[CNT_W-1:LOOP_W]));

    p_loop_end_r7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(mode_i) == 2'd2 && taken_o) |-> (cnt_o[LOOP_W-1:0] != '1));

    p_always_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(mode_i) == 2'd0 && $past(code_i) == 4'd1) |-> taken_o);

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(mode_i) == 2'd3) |-> (!taken_o && !exit_o && set_byte_o == '0));
endmodule

bind cond_branch_unit cbu_checker #(.CNT_W(CNT_W), .LOOP_W(LOOP_W), .BYTE_W(BYTE_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .code_i(code_i), .cnt_i(cnt_i),
    .taken_o(taken_o), .exit_o(exit_o), .set_byte_o(set_byte_o), .cnt_o(cnt_o)
);

// File: tb/test_cond_branch_unit.sv
`timescale 1ns/1ps
module test_cond_branch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = '0;
    logic [3:0]  code_i = '0;
    logic        fn = 1'b0, fz = 1'b0, fv = 1'b0, fc = 1'b0;
    logic [31:0] cnt_i = '0;
    logic        taken_o, exit_o;
    logic [7:0]  set_byte_o;
    logic [31:0] cnt_o;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    cond_branch_unit i_cond_branch_unit (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .code_i(code_i),
        .flag_n_i(fn), .flag_z_i(fz), .flag_v_i(fv), .flag_c_i(fc),
        .cnt_i(cnt_i), .taken_o(taken_o), .exit_o(exit_o),
        .set_byte_o(set_byte_o), .cnt_o(cnt_o)
    );

    function automatic logic ref_cond(input logic [3:0] k, input logic n, z, v, c);
        case (k)
            4'd0:  return 1'b1;
            4'd1:  return 1'b0;
            4'd2:  return (c == 0) && (z == 0);
            4'd3:  return (c == 1) || (z == 1);
            4'd4:  return c == 0;
            4'd5:  return c == 1;
            4'd6:  return z == 0;
            4'd7:  return z == 1;
            4'd8:  return v == 0;
            4'd9:  return v == 1;
            4'd10: return n == 0;
            4'd11: return n == 1;
            4'd12: return n == v;
            4'd13: return n != v;
            4'd14: return (z == 0) && (n == v);
            default: return (z == 1) || (n != v);
        endcase
    endfunction

    task automatic check(input string tag, input logic [41:0] act, input logic [41:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'hA5A5_0000;
        pats[1] = 32'h1234_0001;
        pats[2] = 32'h0000_0007;
        pats[3] = 32'hFFFF_8000;

        cnt_i = 32'hDEAD_BEEF;
        mode_i = 2'd2;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 reset", {taken_o, exit_o, set_byte_o, cnt_o}, 42'd0);
        rst_n = 1'b1;

        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 16; k++) begin
                for (int f = 0; f < 16; f++) begin
                    for (int p = 0; p < 4; p++) begin
                        logic        cond, e_tk, e_ex;
                        logic [7:0]  e_by;
                        logic [31:0] e_cn;
                        logic [15:0] lo;
                        string       tag;
                        @(negedge clk);
                        mode_i = 2'(m); code_i = 4'(k);
                        {fn, fz, fv, fc} = 4'(f);
                        cnt_i = pats[p];
                        cond = ref_cond(4'(k), fn, fz, fv, fc);
                        e_tk = 0; e_ex = 0; e_by = 8'h00; e_cn = cnt_i;
                        if (m == 0) begin
                            e_tk = cond || (k == 1);
                            if (k == 2 || k == 3)   tag = "R2 unsigned cond (branch R4)";
                            else if (k >= 12)       tag = "R3 signed cond (branch R4)";
                            else                    tag = "R1 simple cond (branch R4)";
                        end else if (m == 1) begin
                            e_by = cond ? 8'hFF : 8'h00;
                            tag = "R5 set byte";
                        end else if (m == 2) begin
                            if (cond) begin
                                e_ex = 1;
                                tag = "R6 loop exit";
                            end else begin
                                lo = cnt_i[15:0] - 16'd1;
                                e_cn = {cnt_i[31:16], lo};
                                e_tk = (lo != 16'hFFFF);
                                tag = "R7 loop decrement";
                            end
                        end else begin
                            tag = "R10 idle";
                        end
                        @(negedge clk);
                        check(tag, {taken_o, exit_o, set_byte_o, cnt_o}, {e_tk, e_ex, e_by, e_cn});
                        check("R8 upper bits", {26'd0, cnt_o[31:16]}, {26'd0, cnt_i[31:16]});
                    end
                end
            end
        end

        // R9: counted loop with code F starting at 7
        begin
            int passes = 0;
            int takes  = 0;
            logic [31:0] c = 32'hABCD_0007;
            for (int it = 0; it < 20; it++) begin
                @(negedge clk);
                mode_i = 2'd2; code_i = 4'd1;
                {fn, fz, fv, fc} = 4'(it);
                cnt_i = c;
                @(negedge clk);
                passes++;
                c = cnt_o;
                if (taken_o) takes++;
                else break;
            end
            check("R9 pass count", 42'(passes), 42'd8);
            check("R9 taken count", 42'(takes), 42'd7);
            check("R9 final counter", {10'd0, c}, {10'd0, 32'hABCD_FFFF});
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule